// File: doc/BRIEF.md
# Vectored Interrupt Priority Resolver

This block keeps a pending bit and an enable bit for each maskable interrupt source, a global interrupt enable and a latched software-trap flag. It asks a simple core to take an interrupt whenever the global enable is on and either an enabled source is pending or the trap flag is set. When the core takes the interrupt, the global enable drops and the block hands back the fixed entry address 0x00FF as a jump target.

The service routine at the entry address later issues a vector-select request carrying its own program counter. At that moment the block picks the highest-ranked active source. It finds the vector table in the top 32 bytes of the 256-byte page holding the request, or in the following page when the request sits on the last byte of a page. It then reads the two vector bytes from program ROM, high byte first, and returns the 15-bit jump target. Pending bits stay set until an explicit clear strobe. Any lower-ranked source that is still pending therefore requests again as soon as return-from-interrupt sets the global enable.

Top module: `vint_resolver`

## Requirements
- R1: `irq_o` is high exactly when `gie_o` is high and either the trap flag is set or some source has both its pending bit and `src_en_i` bit set; it follows `src_en_i` in the same cycle.
- R2: `take_i` while `irq_o` is high clears the global enable at the next edge, and in the following cycle `target_vld_o` pulses for one cycle with `target_o` = 0x00FF.
- R3: After reset the global enable is 0. At an edge, an accepted take clears it first, then `gie_clr_i` clears it, and otherwise `gie_set_i` or `reti_i` sets it.
- R4: A one-cycle `evt_i[k]` sets pending bit k and `pend_clr_i[k]` clears it. When both arrive in the same cycle the bit ends set. Neither a take nor a vector select clears a pending bit.
- R5: A one-cycle `trap_i` sets the trap flag, which `src_en_i` cannot mask. `reti_i` clears it, and `trap_i` wins when both arrive in one cycle.
- R6: Rank is resolved from the state at the edge where `vsel_i` is sampled. The trap outranks all sources, and among enabled pending sources the one with the larger index k ranks higher.
- R7: The low byte of the high-order vector address is 0xE0 + 2k for maskable source k, 0xFE for the trap, and 0xE0 when nothing is active. The low-order byte sits at that address plus one.
- R8: The table page (address bits 14:8) is `vsel_pc_i[14:8]`, plus one when `vsel_pc_i[7:0]` = 0xFF, taken modulo 128.
- R9: If the table page is 0, `vsel_err_o` pulses for one cycle after the request edge and no ROM read is made.
- R10: With ROM data arriving one cycle after its address, `rom_rd_o` is high for the two cycles after the request edge (high-order address first, then plus one). Two cycles later `target_vld_o` pulses with `target_o` = {high byte bits 6:0, low byte}.
- R11: A `vsel_i` that arrives while a fetch is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_SRC | One-cycle event per source |
| src_en_i | input | NUM_SRC | Per-source enable levels |
| pend_clr_i | input | NUM_SRC | Pending-clear strobes |
| trap_i | input | 1 | Software-trap strobe |
| gie_set_i | input | 1 | Set global enable |
| gie_clr_i | input | 1 | Clear global enable |
| take_i | input | 1 | Core takes the requested interrupt |
| reti_i | input | 1 | Return-from-interrupt strobe |
| vsel_i | input | 1 | Vector-select request |
| vsel_pc_i | input | PC_W | PC of the vector-select instruction |
| rom_data_i | input | 8 | ROM byte, one cycle after its address |
| irq_o | output | 1 | Interrupt request to the core |
| gie_o | output | 1 | Global enable state |
| rom_rd_o | output | 1 | Vector byte read strobe |
| rom_addr_o | output | PC_W | Vector byte address |
| target_o | output | PC_W | Jump target |
| target_vld_o | output | 1 | Jump target valid pulse |
| vsel_err_o | output | 1 | Table would fall in page 0 |

## Verification
A wrong pending bit or trap flag shows up on `irq_o` in the cycle after the stray edge, provided the global enable is on. It also shows up in the vector address chosen by the next vector select. A wrong rank or page computation shows up on `rom_addr_o` one cycle after the request edge. A wrong byte order or latch timing shows up on `target_o` three cycles after it. The bench tracks pending, trap and enable state in its own model and compares `irq_o` and `gie_o` every cycle, so a fault there is reported within one cycle.

// File: rtl/vint_pkg.sv
package vint_pkg;
   typedef enum logic [1:0] {FS_IDLE, FS_HI, FS_LO, FS_FIN} fstate_e;
   localparam logic [7:0] TBL_BASE  = 8'hE0;
   localparam logic [7:0] TRAP_SLOT = 8'hFE;
   localparam logic [7:0] ENTRY_OFS = 8'hFF;
   localparam int         MAX_SRC   = 14;
endpackage

// File: rtl/vint_pending.sv
module vint_pending #(
   parameter int NUM_SRC = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] pend_o
);
   logic [NUM_SRC-1:0] pend_q;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                pend_q[g] <= 1'b0;
         else if (evt_i[g])         pend_q[g] <= 1'b1;
         else if (clr_i[g])         pend_q[g] <= 1'b0;
      end

      // R4: an event is never lost, even against a clear
      a_r4_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
         evt_i[g] |=> pend_q[g]);
      // R4: without event or clear the bit does not move
      a_r4_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (!evt_i[g] && !clr_i[g]) |=> (pend_q[g] == $past(pend_q[g])));
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/vint_prio.sv
module vint_prio #(
   parameter int NUM_SRC       = 14,
   parameter bit HIGH_IDX_WINS = 1'b1,
   localparam int IDX_W        = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] req_i,
   output logic               hit_o,
   output logic [IDX_W-1:0]   idx_o
);
   if (HIGH_IDX_WINS) begin : g_high
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < NUM_SRC; i++)
            if (req_i[i]) idx_o = IDX_W'(i);
      end
   end else begin : g_low
      always_comb begin
         idx_o = '0;
         for (int i = NUM_SRC - 1; i >= 0; i--)
            if (req_i[i]) idx_o = IDX_W'(i);
      end
   end

   assign hit_o = |req_i;

   // R6: the chosen index is itself a requesting source
   always_comb begin
      if (hit_o) a_r6_idx_requests: assert (req_i[idx_o]);
   end
endmodule

// File: rtl/vint_fetch.sv
module vint_fetch
   import vint_pkg::*;
#(
   parameter int  NUM_SRC = 14,
   parameter int  PC_W    = 15,
   localparam int IDX_W   = $clog2(NUM_SRC),
   localparam int PAGE_W  = PC_W - 8,
   localparam int HI_W    = PC_W - 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vsel_i,
   input  logic [PC_W-1:0]  vsel_pc_i,
   input  logic             trap_act_i,
   input  logic             hit_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             take_fire_i,
   input  logic [7:0]       rom_data_i,
   output logic             rom_rd_o,
   output logic [PC_W-1:0]  rom_addr_o,
   output logic [PC_W-1:0]  target_o,
   output logic             target_vld_o,
   output logic             vsel_err_o
);
   localparam logic [PC_W-1:0] ENTRY_PC = PC_W'(ENTRY_OFS);

   fstate_e         st_q;
   logic [PC_W-1:0] addr_q;
   logic [HI_W-1:0] hi_q;
   logic [PC_W-1:0] tgt_q;
   logic            vld_q;
   logic            err_q;
   logic [PAGE_W-1:0] page_c;
   logic [7:0]        slot_c;

   always_comb begin
      page_c = vsel_pc_i[PC_W-1:8] + PAGE_W'(vsel_pc_i[7:0] == 8'hFF);
      if (trap_act_i)  slot_c = TRAP_SLOT;
      else if (hit_i)  slot_c = TBL_BASE + 8'({idx_i, 1'b0});
      else             slot_c = TBL_BASE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= FS_IDLE;
         addr_q <= '0;
         hi_q   <= '0;
         tgt_q  <= '0;
         vld_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         err_q <= 1'b0;
         if (take_fire_i) begin
            tgt_q <= ENTRY_PC;
            vld_q <= 1'b1;
         end
         unique case (st_q)
            FS_IDLE: if (vsel_i) begin
               if (page_c == '0) err_q <= 1'b1;
               else begin
                  addr_q <= {page_c, slot_c};
                  st_q   <= FS_HI;
               end
            end
            FS_HI: begin
               addr_q[0] <= 1'b1;
               st_q      <= FS_LO;
            end
            FS_LO: begin
               hi_q <= rom_data_i[HI_W-1:0];
               st_q <= FS_FIN;
            end
            FS_FIN: begin
               tgt_q <= {hi_q, rom_data_i};
               vld_q <= 1'b1;
               st_q  <= FS_IDLE;
            end
            default: st_q <= FS_IDLE;
         endcase
      end
   end

   assign rom_rd_o     = (st_q == FS_HI) || (st_q == FS_LO);
   assign rom_addr_o   = addr_q;
   assign target_o     = tgt_q;
   assign target_vld_o = vld_q;
   assign vsel_err_o   = err_q;

   // R7: every vector read lands in the table window of a page
   a_r7_table_window: assert property (@(posedge clk) disable iff (!rst_n)
      rom_rd_o |-> (rom_addr_o[7:0] >= TBL_BASE));
   // R9: the table never sits in page 0
   a_r9_no_page0_read: assert property (@(posedge clk) disable iff (!rst_n)
      rom_rd_o |-> (rom_addr_o[PC_W-1:8] != '0));
   // R9: an error is never paired with a read
   a_r9_err_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      vsel_err_o |-> !rom_rd_o);
   // R10: low-order byte is read right after the high-order byte
   a_r10_lo_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FS_LO) |-> ($past(rom_rd_o) && rom_addr_o == PC_W'($past(rom_addr_o) + 1'b1)));
   // R10: result appears two cycles after the last read
   a_r10_result_timing: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FS_FIN) |=> target_vld_o);
   // R2: an accepted take outside a fetch result returns the entry address
   a_r2_entry_target: assert property (@(posedge clk) disable iff (!rst_n)
      (take_fire_i && st_q != FS_FIN) |=> (target_vld_o && target_o == ENTRY_PC));
endmodule

// File: rtl/vint_resolver.sv
module vint_resolver
   import vint_pkg::*;
#(
   parameter int NUM_SRC       = 14,
   parameter int PC_W          = 15,
   parameter bit HIGH_IDX_WINS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic [NUM_SRC-1:0] src_en_i,
   input  logic [NUM_SRC-1:0] pend_clr_i,
   input  logic               trap_i,
   input  logic               gie_set_i,
   input  logic               gie_clr_i,
   input  logic               take_i,
   input  logic               reti_i,
   input  logic               vsel_i,
   input  logic [PC_W-1:0]    vsel_pc_i,
   input  logic [7:0]         rom_data_i,
   output logic               irq_o,
   output logic               gie_o,
   output logic               rom_rd_o,
   output logic [PC_W-1:0]    rom_addr_o,
   output logic [PC_W-1:0]    target_o,
   output logic               target_vld_o,
   output logic               vsel_err_o
);
   localparam int IDX_W = $clog2(NUM_SRC);

   if (NUM_SRC < 2 || NUM_SRC > MAX_SRC) begin : g_bad_src
      $error("vint_resolver: NUM_SRC must lie in 2..14");
   end
   if (PC_W < 9 || PC_W > 16) begin : g_bad_pc
      $error("vint_resolver: PC_W must lie in 9..16");
   end

   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] active;
   logic               hit;
   logic [IDX_W-1:0]   idx;
   logic               gie_q;
   logic               trap_q;
   logic               take_fire;

   vint_pending #(.NUM_SRC(NUM_SRC)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i (evt_i),
      .clr_i (pend_clr_i),
      .pend_o(pend)
   );

   assign active = pend & src_en_i;

   vint_prio #(.NUM_SRC(NUM_SRC), .HIGH_IDX_WINS(HIGH_IDX_WINS)) u_prio (
      .req_i(active),
      .hit_o(hit),
      .idx_o(idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          trap_q <= 1'b0;
      else if (trap_i)     trap_q <= 1'b1;
      else if (reti_i)     trap_q <= 1'b0;
   end

   assign irq_o     = gie_q && (hit || trap_q);
   assign take_fire = take_i && irq_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     gie_q <= 1'b0;
      else if (take_fire)             gie_q <= 1'b0;
      else if (gie_clr_i)             gie_q <= 1'b0;
      else if (gie_set_i || reti_i)   gie_q <= 1'b1;
   end
   assign gie_o = gie_q;

   vint_fetch #(.NUM_SRC(NUM_SRC), .PC_W(PC_W)) u_fetch (
      .clk         (clk),
      .rst_n       (rst_n),
      .vsel_i      (vsel_i),
      .vsel_pc_i   (vsel_pc_i),
      .trap_act_i  (trap_q),
      .hit_i       (hit),
      .idx_i       (idx),
      .take_fire_i (take_fire),
      .rom_data_i  (rom_data_i),
      .rom_rd_o    (rom_rd_o),
      .rom_addr_o  (rom_addr_o),
      .target_o    (target_o),
      .target_vld_o(target_vld_o),
      .vsel_err_o  (vsel_err_o)
   );

   // R1: no request without the global enable
   a_r1_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> gie_o);
   // R2: taking the interrupt closes the global enable
   a_r2_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && irq_o) |=> !gie_o);
   // R3: return-from-interrupt reopens the global enable
   a_r3_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_i && !take_fire && !gie_clr_i) |=> gie_o);
   // R5: a latched trap is not masked by source enables
   a_r5_trap_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_q && gie_o) |-> irq_o);
   // R5: the trap strobe always latches
   a_r5_trap_latch: assert property (@(posedge clk) disable iff (!rst_n)
      trap_i |=> trap_q);
endmodule

// File: tb/test_vint_resolver.sv
`timescale 1ns/1ps
module test_vint_resolver;
   localparam int NS = 14;
   localparam int PW = 15;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n;
   logic [NS-1:0] evt, en, clr;
   logic          trap, gset, gclr, take, reti, vsel;
   logic [PW-1:0] vpc;
   logic [7:0]    rom_data;
   logic          irq, gie, rom_rd, tvld, verr;
   logic [PW-1:0] rom_addr, target;

   vint_resolver #(.NUM_SRC(NS), .PC_W(PW)) i_vint_resolver (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .src_en_i(en), .pend_clr_i(clr),
      .trap_i(trap), .gie_set_i(gset), .gie_clr_i(gclr), .take_i(take),
      .reti_i(reti), .vsel_i(vsel), .vsel_pc_i(vpc), .rom_data_i(rom_data),
      .irq_o(irq), .gie_o(gie), .rom_rd_o(rom_rd), .rom_addr_o(rom_addr),
      .target_o(target), .target_vld_o(tvld), .vsel_err_o(verr));

   function automatic logic [7:0] romf(input logic [PW-1:0] a);
      return a[7:0] ^ 8'({1'b0, a[14:8]} * 8'd37) ^ 8'h5A;
   endfunction

   always @(posedge clk) rom_data <= romf(rom_addr);

   int checks = 0;
   int fails  = 0;
   logic [NS-1:0] pend_m = '0;
   logic          trap_m = 1'b0;
   logic          gie_m  = 1'b0;
   logic          exp_entry = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic irq_model(input logic [NS-1:0] e);
      return gie_m && ((|(pend_m & e)) || trap_m);
   endfunction

   task automatic step(input logic [NS-1:0] e_v, input logic [NS-1:0] c_v, input logic [NS-1:0] en_v,
                       input logic tr, input logic rt, input logic tk, input logic gs, input logic gc);
      logic irq_now;
      @(negedge clk);
      chk("R1 irq", 32'(irq), 32'(irq_model(en)));
      chk("R3 gie", 32'(gie), 32'(gie_m));
      if (exp_entry) begin
         chk("R2 entry valid", 32'(tvld), 32'd1);
         chk("R2 entry target", 32'(target), 32'h00FF);
      end
      evt = e_v; clr = c_v; en = en_v; trap = tr; reti = rt; take = tk; gset = gs; gclr = gc;
      irq_now = irq_model(en_v);
      @(posedge clk);
      pend_m = (pend_m & ~c_v) | e_v;
      if (tr) trap_m = 1'b1; else if (rt) trap_m = 1'b0;
      if (tk && irq_now) gie_m = 1'b0;
      else if (gc) gie_m = 1'b0;
      else if (gs || rt) gie_m = 1'b1;
      exp_entry = tk && irq_now;
   endtask

   task automatic idle();
      step('0, '0, en, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic do_vsel(input logic [PW-1:0] pc, input logic busy_try);
      logic [NS-1:0] act;
      logic [7:0]    slot;
      logic [6:0]    page;
      logic [PW-1:0] ha;
      logic [PW-1:0] exp_t;
      @(negedge clk);
      evt = '0; clr = '0; trap = 0; reti = 0; take = 0; gset = 0; gclr = 0;
      act  = pend_m & en;
      slot = 8'hE0;
      for (int i = 0; i < NS; i++) if (act[i]) slot = 8'hE0 + 8'(2 * i);
      if (trap_m) slot = 8'hFE;
      page = pc[14:8] + 7'(pc[7:0] == 8'hFF);
      vsel = 1'b1; vpc = pc;
      @(negedge clk);
      vsel = 1'b0;
      if (page == 7'd0) begin
         chk("R9 error pulse", 32'(verr), 32'd1);
         chk("R9 no read", 32'(rom_rd), 32'd0);
         @(negedge clk);
         chk("R9 error ends", 32'(verr), 32'd0);
         chk("R9 still no read", 32'(rom_rd), 32'd0);
      end else begin
         ha = {page, slot};
         exp_t = {romf(ha)[6:0], romf(ha + 1'b1)};
         chk("R10 high read", 32'(rom_rd), 32'd1);
         chk("R6 R7 R8 high address", 32'(rom_addr), 32'(ha));
         if (busy_try) begin vsel = 1'b1; vpc = 15'h2210; end
         @(negedge clk);
         vsel = 1'b0;
         chk("R10 low read", 32'(rom_rd), 32'd1);
         chk("R7 low address", 32'(rom_addr), 32'(ha + 1'b1));
         @(negedge clk);
         chk("R10 reads done", 32'(rom_rd), 32'd0);
         @(negedge clk);
         chk("R10 target valid", 32'(tvld), 32'd1);
         chk("R10 target value", 32'(target), 32'(exp_t));
         @(negedge clk);
         chk("R11 no second fetch", 32'(rom_rd), 32'd0);
         chk("R11 valid is a pulse", 32'(tvld), 32'd0);
      end
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1711));
      rst_n = 1'b0; evt = '0; en = '0; clr = '0; trap = 0; gset = 0; gclr = 0;
      take = 0; reti = 0; vsel = 0; vpc = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      chk("R3 reset gie", 32'(gie), 32'd0);
      chk("R1 reset irq", 32'(irq), 32'd0);
      chk("R10 reset no read", 32'(rom_rd), 32'd0);
      chk("R9 reset no error", 32'(verr), 32'd0);

      // R1: pending with gie off gives no request, then gie on
      step(14'h0008, '0, '1, 0, 0, 0, 0, 0);
      idle();
      step('0, '0, '1, 0, 0, 0, 1, 0);
      idle();
      // R1: removing the enable drops the request at once
      step('0, '0, '0, 0, 0, 0, 0, 0);
      step('0, '0, '1, 0, 0, 0, 0, 0);
      // R2: take
      step('0, '0, '1, 0, 0, 1, 0, 0);
      idle();
      // R6: higher rank arrives after entry
      step(14'h0200, '0, '1, 0, 0, 0, 0, 0);
      idle();
      do_vsel(15'h1234, 1'b0);
      // R4: clear and event together keep the bit
      step(14'h0200, 14'h0200, '1, 0, 0, 0, 0, 0);
      idle();
      do_vsel(15'h1234, 1'b0);
      step('0, 14'h0200, '1, 0, 0, 0, 0, 0);
      idle();
      do_vsel(15'h3456, 1'b0);
      // R4: source 3 still pending fires after reti
      step('0, '0, '1, 0, 1, 0, 0, 0);
      idle();
      // R3: take beats reti in the same cycle
      step('0, '0, '1, 0, 1, 1, 0, 0);
      idle();
      // R5: trap with all enables off
      step('0, 14'h0008, '0, 1, 0, 0, 0, 0);
      step('0, '0, '0, 0, 0, 0, 1, 0);
      idle();
      do_vsel(15'h4567, 1'b0);
      // R5: trap strobe wins over reti
      step('0, '0, '0, 1, 1, 0, 0, 0);
      idle();
      step('0, '0, '0, 0, 1, 0, 0, 0);
      idle();
      // R7: nothing active falls back to the lowest slot
      do_vsel(15'h0A00, 1'b0);
      // R8: last byte of page moves the table up
      do_vsel(15'h00FF, 1'b0);
      do_vsel(15'h12FF, 1'b0);
      // R9: page 0 and wrap-around to page 0
      do_vsel(15'h0042, 1'b0);
      do_vsel(15'h7FFF, 1'b0);
      // R11: request while busy
      step(14'h2000, '0, '1, 0, 0, 0, 0, 0);
      idle();
      do_vsel(15'h5A10, 1'b1);
      // R3: clear wins over set
      step('0, '0, '1, 0, 0, 0, 1, 1);
      idle();

      for (int n = 0; n < 400; n++) begin
         logic [NS-1:0] e_r, c_r, en_r;
         e_r  = NS'($urandom) & NS'($urandom) & NS'($urandom);
         c_r  = NS'($urandom) & NS'($urandom);
         en_r = NS'($urandom);
         step(e_r, c_r, en_r, ($urandom % 23) == 0, ($urandom % 7) == 0,
              ($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 9) == 0);
         if (n % 10 == 9) begin
            idle();
            do_vsel(PW'($urandom), ($urandom % 3) == 0);
         end
      end
      idle();
      idle();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule